// File: doc/BRIEF.md
# Hit-Pattern Channel Readout Selector

This block decides which of 64 front-end channels are handed to the converter after a trigger. Once armed, it ORs every channel's discriminator hit into a hit register. A trigger freezes that register. The frozen pattern and a count of its set bits stay on the outputs, so a first-level trigger can use the multiplicity and a second-level trigger can use the pattern.

When readout is started, the block builds a selection set. Depending on the configured mode, this is every channel, the hit channels only, or a 64-bit mask loaded at run time. In hit mode the pattern can first be widened so that the direct neighbours of each hit channel are also converted. The selected channel indices then leave one at a time, in ascending order, on a valid/ready stream. The final index carries a last flag, and a one-cycle done pulse follows. The hit register is kept until a clear strobe returns the block to idle.

The controller has six states:
- `ST_IDLE` moves to `ST_ARMED` on `arm_i`.
- `ST_ARMED` collects hits and moves to `ST_HELD` on `trig_i`.
- `ST_HELD` holds the pattern. On `start_i` it moves to `ST_SCAN`, or straight to `ST_DONE` if the selected set is empty.
- `ST_SCAN` emits indices. After the last one is accepted it moves to `ST_DONE`.
- `ST_DONE` always moves to `ST_PARKED` after one cycle.
- `ST_PARKED` returns to `ST_IDLE` on `clr_i`, which also clears the hit register.

Top module: `hit_readout_sel`

## Requirements
- R1: After reset, `idx_valid_o` and `done_o` are low, and `hit_pattern_o` and `hit_count_o` are zero.
- R2: A channel's hit bit is set only if its discriminator input is high in a cycle where the block is armed. Armed means from the cycle after `arm_i` up to and including the cycle in which `trig_i` is seen. Hits seen before arming or after the trigger are ignored.
- R3: `hit_count_o` equals the number of set bits in `hit_pattern_o`.
- R4: With control register (address 0) bits [1:0] = 1, the stream carries exactly the indices of the hit channels, in ascending order.
- R5: With control bit 2 set in hit mode, channels i-1 and i+1 of every hit channel i are added. There is no wrap-around: channel 0 has no lower neighbour and channel 63 has no upper neighbour.
- R6: Mode values 0 and 3 stream every channel, 0 to 63 in order.
- R7: Mode value 2 streams the channels set in the run-time mask. Address 2 holds channels 31..0 and address 3 holds channels 63..32. The mask is sampled when readout starts, so a later write does not change a readout in progress.
- R8: An index is accepted in each cycle where valid and `idx_ready_i` are both high. While ready is low, valid and the index hold steady.
- R9: `idx_last_o` is high only with the final index. `done_o` is high for exactly one cycle, the cycle after the final index is accepted.
- R10: If the selected set is empty, no index is produced and `done_o` pulses in the cycle after `start_i`.
- R11: The hit pattern is kept through readout. A `clr_i` after done clears it and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_hit_i | input | 64 | One discriminator hit bit per channel |
| arm_i | input | 1 | Arm strobe, accepted in idle |
| trig_i | input | 1 | Trigger strobe, freezes the hit pattern |
| start_i | input | 1 | Start-readout strobe, accepted after the trigger |
| clr_i | input | 1 | Clears hits after done and returns to idle |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | Configuration address: 0 control, 2 and 3 mask words |
| cfg_wdata_i | input | 32 | Configuration write data |
| idx_ready_i | input | 1 | Downstream ready |
| idx_o | output | 6 | Channel index to convert |
| idx_valid_o | output | 1 | Index valid |
| idx_last_o | output | 1 | Final index of this readout |
| done_o | output | 1 | One-cycle end-of-readout pulse |
| hit_pattern_o | output | 64 | Latched hit register |
| hit_count_o | output | 7 | Number of hit channels |

## Verification
Each result has a fixed latency, and the bench samples it on the falling edge of the cycle in which it is due:
- A hit driven in an armed cycle appears in the pattern and the count one clock later.
- The first index is visible in the cycle after the clock edge that takes `start_i`.
- Each accepted index is replaced by the next one after a single edge.
- `done_o` is expected exactly one cycle after the final accept, or one cycle after the start for an empty set, and must be gone a cycle later.

The readout loop records the cycle number of every accept and of the done pulse and compares those numbers, not only the order of the indices. Stalled runs also check that the index held across each cycle with ready low.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [1:0] {
        RD_ALL     = 2'd0,
        RD_HITS    = 2'd1,
        RD_MASK    = 2'd2,
        RD_ALL_ALT = 2'd3
    } rd_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HELD,
        ST_SCAN,
        ST_DONE,
        ST_PARKED
    } hrs_state_t;

    localparam int CTRL_ADDR = 0;
    localparam int MASK_BASE = 2;

endpackage

// File: rtl/hrs_cfg_regs.sv
module hrs_cfg_regs
    import hrs_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int CFG_W = 32,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [CFG_W-1:0] wdata,
    output rd_mode_t         mode_o,
    output logic             nbr_en_o,
    output logic [NCH-1:0]   mask_o
);
    localparam int NWORDS = NCH / CFG_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= RD_ALL;
            nbr_en_o <= 1'b0;
        end else if (we && addr == AW'(CTRL_ADDR)) begin
            mode_o   <= rd_mode_t'(wdata[1:0]);
            nbr_en_o <= wdata[2];
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_mask_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_o[w*CFG_W +: CFG_W] <= '0;
            end else if (we && addr == AW'(MASK_BASE + w)) begin
                mask_o[w*CFG_W +: CFG_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/hrs_hit_latch.sv
module hrs_hit_latch #(
    parameter int NCH = 64,
    parameter int CW  = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic           clear,
    input  logic [NCH-1:0] disc,
    output logic [NCH-1:0] pattern_o,
    output logic [CW-1:0]  count_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pattern_o <= '0;
        end else if (capture) begin
            pattern_o <= pattern_o | disc;
        end
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < NCH; i++) begin
            count_o = count_o + CW'(pattern_o[i]);
        end
    end

endmodule

// File: rtl/hrs_sel_build.sv
module hrs_sel_build
    import hrs_pkg::*;
#(
    parameter int NCH = 64
) (
    input  logic [NCH-1:0] hits,
    input  rd_mode_t       mode,
    input  logic           nbr_en,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] sel_o
);
    logic [NCH-1:0] widened;

    // Shifts fill with zero, so neither end wraps around.
    always_comb begin
        widened = hits;
        if (nbr_en) begin
            widened = hits | (hits << 1) | (hits >> 1);
        end
    end

    always_comb begin
        unique case (mode)
            RD_HITS:    sel_o = widened;
            RD_MASK:    sel_o = mask;
            RD_ALL,
            RD_ALL_ALT: sel_o = '1;
            default:    sel_o = '1;
        endcase
    end

endmodule

// File: rtl/hrs_pick.sv
module hrs_pick #(
    parameter int NCH = 64,
    parameter int IW  = 6
) (
    input  logic [NCH-1:0] pend,
    output logic [IW-1:0]  idx_o,
    output logic           any_o,
    output logic           single_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign any_o    = |pend;
    assign single_o = any_o && ((pend & (pend - NCH'(1))) == '0);

endmodule

// File: rtl/hit_readout_sel.sv
module hit_readout_sel
    import hrs_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int CFG_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             disc_hit_i,
    input  logic                       arm_i,
    input  logic                       trig_i,
    input  logic                       start_i,
    input  logic                       clr_i,
    input  logic                       cfg_we_i,
    input  logic [$clog2(MASK_BASE + NCH/CFG_W)-1:0] cfg_addr_i,
    input  logic [CFG_W-1:0]           cfg_wdata_i,
    input  logic                       idx_ready_i,
    output logic [$clog2(NCH)-1:0]     idx_o,
    output logic                       idx_valid_o,
    output logic                       idx_last_o,
    output logic                       done_o,
    output logic [NCH-1:0]             hit_pattern_o,
    output logic [$clog2(NCH+1)-1:0]   hit_count_o
);
    localparam int IW = $clog2(NCH);
    localparam int CW = $clog2(NCH + 1);
    localparam int AW = $clog2(MASK_BASE + NCH / CFG_W);

    hrs_state_t     state, nxt;
    rd_mode_t       mode;
    logic           nbr_en;
    logic [NCH-1:0] mask;
    logic [NCH-1:0] sel;
    logic [NCH-1:0] pend;
    logic [IW-1:0]  pick_idx;
    logic           pick_any, pick_single;
    logic           accept;

    hrs_cfg_regs #(.NCH(NCH), .CFG_W(CFG_W), .AW(AW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we_i),
        .addr     (cfg_addr_i),
        .wdata    (cfg_wdata_i),
        .mode_o   (mode),
        .nbr_en_o (nbr_en),
        .mask_o   (mask)
    );

    hrs_hit_latch #(.NCH(NCH), .CW(CW)) u_hits (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (state == ST_ARMED),
        .clear     (state == ST_PARKED && clr_i),
        .disc      (disc_hit_i),
        .pattern_o (hit_pattern_o),
        .count_o   (hit_count_o)
    );

    hrs_sel_build #(.NCH(NCH)) u_sel (
        .hits   (hit_pattern_o),
        .mode   (mode),
        .nbr_en (nbr_en),
        .mask   (mask),
        .sel_o  (sel)
    );

    hrs_pick #(.NCH(NCH), .IW(IW)) u_pick (
        .pend     (pend),
        .idx_o    (pick_idx),
        .any_o    (pick_any),
        .single_o (pick_single)
    );

    assign accept = (state == ST_SCAN) && idx_ready_i && pick_any;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (arm_i)   nxt = ST_ARMED;
            ST_ARMED:  if (trig_i)  nxt = ST_HELD;
            ST_HELD:   if (start_i) nxt = (sel == '0) ? ST_DONE : ST_SCAN;
            ST_SCAN:   if (accept && pick_single) nxt = ST_DONE;
            ST_DONE:   nxt = ST_PARKED;
            ST_PARKED: if (clr_i)   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Pending selection: loaded at start, one bit retired per accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (state == ST_HELD && start_i) begin
            pend <= sel;
        end else if (accept) begin
            pend[pick_idx] <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        idx_o       = pick_idx;
        idx_valid_o = (state == ST_SCAN) && pick_any;
        idx_last_o  = (state == ST_SCAN) && pick_single;
        done_o      = (state == ST_DONE);
    end

endmodule

// File: rtl/hrs_checker.sv
module hrs_checker #(
    parameter int NCH = 64,
    parameter int IW  = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr_i,
    input logic           idx_ready_i,
    input logic [IW-1:0]  idx_o,
    input logic           idx_valid_o,
    input logic           idx_last_o,
    input logic           done_o,
    input logic [NCH-1:0] hit_pattern_o
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid_o && !idx_ready_i) |=> (idx_valid_o && $stable(idx_o)));

    assert_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid_o && idx_ready_i && !idx_last_o) |=> (!idx_valid_o || idx_o > $past(idx_o)));

    assert_last_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid_o && idx_ready_i && idx_last_o) |=> done_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_no_valid_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !idx_valid_o);

    assert_keep_hits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (($past(hit_pattern_o) & ~hit_pattern_o) == '0));

endmodule

bind hit_readout_sel hrs_checker #(.NCH(NCH), .IW($clog2(NCH))) u_hrs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (clr_i),
    .idx_ready_i   (idx_ready_i),
    .idx_o         (idx_o),
    .idx_valid_o   (idx_valid_o),
    .idx_last_o    (idx_last_o),
    .done_o        (done_o),
    .hit_pattern_o (hit_pattern_o)
);

// File: tb/tb_hit_readout_sel.sv
module tb_hit_readout_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] disc = '0;
    logic        arm = 1'b0, trig = 1'b0, start = 1'b0, clr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ready = 1'b1;
    logic [5:0]  idx;
    logic        valid, last, done;
    logic [63:0] pattern;
    logic [6:0]  count;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    hit_readout_sel dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .disc_hit_i    (disc),
        .arm_i         (arm),
        .trig_i        (trig),
        .start_i       (start),
        .clr_i         (clr),
        .cfg_we_i      (cfg_we),
        .cfg_addr_i    (cfg_addr),
        .cfg_wdata_i   (cfg_wdata),
        .idx_ready_i   (ready),
        .idx_o         (idx),
        .idx_valid_o   (valid),
        .idx_last_o    (last),
        .done_o        (done),
        .hit_pattern_o (pattern),
        .hit_count_o   (count)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Arm, present hits, trigger, with noise outside the armed window (R2, R3)
    task automatic capture(input logic [63:0] hits, input logic [63:0] noise);
        disc = noise;
        tick(); tick();
        arm = 1'b1; disc = '0;
        tick();
        arm = 1'b0; disc = hits;
        tick();
        disc = '0; trig = 1'b1;
        tick();
        trig = 1'b0; disc = noise;
        tick();
        disc = '0;
        @(negedge clk);
        chk(pattern == hits, "R2 latched pattern", pattern, hits);
        chk(count == 7'($countones(hits)), "R3 multiplicity", 64'(count), 64'($countones(hits)));
        tick();
    endtask

    // Start readout and follow the stream; stall>0 drops ready every stall-th cycle
    task automatic readout(input logic [63:0] exp, input int stall, input bit scribble, input string req);
        logic [63:0] rem = exp;
        int last_acc = -1;
        int done_cyc = -1;
        bit prev_stall = 0;
        logic [5:0] prev_idx = '0;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int cyc = 0; cyc < 300 && done_cyc < 0; cyc++) begin
            ready = (stall == 0) || ((cyc % stall) != 0);
            if (scribble && cyc == 0) begin
                cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'hFFFF_FFFF;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
            if (prev_stall) begin
                chk(valid && idx == prev_idx, "R8 hold while stalled", 64'(idx), 64'(prev_idx));
            end
            prev_stall = valid && !ready;
            prev_idx = idx;
            if (valid && ready) begin
                logic [5:0] want = '0;
                for (int i = 63; i >= 0; i--) if (rem[i]) want = 6'(i);
                chk(rem != '0 && idx == want, req, 64'(idx), 64'(want));
                chk(last == ((rem & (rem - 64'd1)) == '0), "R9 last flag", 64'(last), 64'((rem & (rem - 64'd1)) == '0));
                rem[want] = 1'b0;
                last_acc = cyc;
            end
            if (done) done_cyc = cyc;
            tick();
        end
        cfg_we = 1'b0;
        ready = 1'b1;
        chk(rem == '0, {req, " all indices delivered"}, rem, 64'd0);
        if (exp == '0) begin
            chk(done_cyc == 0 && last_acc == -1, "R10 empty set done at once", 64'(done_cyc), 64'd0);
        end else begin
            chk(done_cyc == last_acc + 1, "R9 done after final accept", 64'(done_cyc), 64'(last_acc + 1));
        end
        @(negedge clk);
        chk(!done, "R9 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic clear_and_check(input logic [63:0] held);
        @(negedge clk);
        chk(pattern == held, "R11 pattern kept after readout", pattern, held);
        #4;
        clr = 1'b1;
        tick();
        clr = 1'b0;
        @(negedge clk);
        chk(pattern == '0 && count == '0, "R11 cleared", pattern, 64'd0);
        tick();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!valid && !done, "R1 reset outputs", {62'd0, valid, done}, 64'd0);
        chk(pattern == '0 && count == '0, "R1 reset pattern", pattern, 64'd0);
    endtask

    task automatic t_hits_plain();
        logic [63:0] h = (64'd1 << 3) | (64'd1 << 10) | (64'd1 << 40);
        cfg_write(2'd0, 32'd1);
        capture(h, 64'hF0F0_0000_0000_00F0);
        readout(h, 0, 0, "R4 hit-only order");
        clear_and_check(h);
    endtask

    task automatic t_hits_nbr();
        logic [63:0] h = (64'd1 << 0) | (64'd1 << 5) | (64'd1 << 63);
        logic [63:0] e = (64'd1 << 0) | (64'd1 << 1) | (64'd1 << 4) | (64'd1 << 5)
                       | (64'd1 << 6) | (64'd1 << 62) | (64'd1 << 63);
        cfg_write(2'd0, 32'd5);
        capture(h, '0);
        readout(e, 3, 0, "R5 neighbour expansion");
        clear_and_check(h);
    endtask

    task automatic t_all(input logic [1:0] m);
        logic [63:0] h = 64'h0000_0100_0000_0002;
        cfg_write(2'd0, {30'd0, m});
        capture(h, '0);
        readout('1, (m == 2'd3) ? 2 : 0, 0, "R6 all channels");
        clear_and_check(h);
    endtask

    task automatic t_mask();
        logic [63:0] m = 64'h8000_0001_0000_0024;
        cfg_write(2'd0, 32'd2);
        cfg_write(2'd2, m[31:0]);
        cfg_write(2'd3, m[63:32]);
        capture(64'd1 << 7, '0);
        readout(m, 0, 1, "R7 mask order, late write ignored");
        clear_and_check(64'd1 << 7);
    endtask

    task automatic t_empty();
        cfg_write(2'd0, 32'd1);
        capture('0, 64'hFFFF_FFFF_FFFF_FFFF);
        readout('0, 0, 0, "R10 empty hit set");
        clear_and_check('0);
        cfg_write(2'd0, 32'd2);
        cfg_write(2'd2, 32'd0);
        cfg_write(2'd3, 32'd0);
        capture(64'd1 << 9, '0);
        readout('0, 0, 0, "R10 empty mask");
        clear_and_check(64'd1 << 9);
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_hits_plain();
        t_hits_nbr();
        t_all(2'd0);
        t_all(2'd3);
        t_mask();
        t_empty();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule